// File: doc/BRIEF.md
# Chained Descriptor Transfer Sequencer

This block moves single data words on behalf of peripherals without CPU involvement. A peripheral raises a pulse on its line of `act_req`. If that source is enabled, the pulse is held in a pending latch. When the sequencer is idle, it serves the lowest-numbered pending source. Serving a source means the following steps. The sequencer reads the source's vector word from a table, and that word names one of 24 descriptors. It then reads the four descriptor words, moves one word from the descriptor's source address to its destination address, and writes the updated count and addresses back. All memory traffic goes over one single-master port. A read request returns its data in the following cycle, and a write takes effect at the clock edge.

A descriptor can be linked to the descriptor with the next index. In that case the next descriptor is processed at once, unless the NMI flag input is high at the link decision. When a count expires, the sequencer pulses `irq` with the source number and clears that source's enable bit. A counter that reaches its end in repeat mode also reloads itself and rewinds its incrementing addresses.

The controller walks these states:
- IDLE: moves to VEC_REQ when a request is pending, and grants that request.
- VEC_REQ, then VEC_TAKE: if the vector holds an invalid index, VEC_TAKE returns to IDLE. Otherwise it goes on to CD_W0.
- CD_W0, CD_W1, CD_W2, CD_W3: read the descriptor words in order.
- DATA_RD, then DATA_WR: read and write the data word.
- WB_CNT, WB_SRC, WB_DST: write the descriptor back.
- LINK: goes to CD_W0 when it follows a chain, and to IDLE otherwise.

Top module: `chain_xfer_ctrl`

## Requirements
- R1: A sequence reads the vector word at address VEC_BASE+source. It then reads descriptor words 0 to 3 at DESC_BASE+4*index+0..3. Next it reads the word at the source address and writes that same word to the destination address. Last, it writes descriptor words 1, 2 and 3 back. The vector index sits in bits [4:0] of the vector word.
- R2: Descriptor word 0 holds the control bits: bit 0 repeat mode, bit 1 chain, bit 2 repeat interrupt, bit 3 source increment, bit 4 destination increment, and bits [31:16] the reload size. Word 1 bits [15:0] hold the count, word 2 the source address and word 3 the destination address. After each move the count drops by one. Each address steps up by one when its increment bit is set and stays unchanged otherwise. A count of 0 wraps to 16'hFFFF.
- R3: When the chain bit is 1, the descriptor with index+1 is processed right after write-back, with no new request. When the chain bit is 0, the sequence ends. The chain stops at index 23.
- R4: When `nmi_flag` is 1 at the link decision, the sequence ends and no further descriptor is touched.
- R5: In normal mode, a move that takes the count from 1 to 0 produces a one-cycle `irq` pulse with `irq_src` equal to the source. The same move clears that source's bit in `en_bits`.
- R6: In repeat mode, a count of 1 reloads to the reload size, and each incrementing address goes back to the value it had before the block of moves (address+1-size). The `irq` pulse and enable clear happen only when the repeat-interrupt bit is 1.
- R7: A move that does not expire the count gives no `irq` and leaves `en_bits` unchanged.
- R8: `busy` is high from VEC_REQ until the sequence ends, which is 12 cycles for one unchained descriptor. Requests that arrive meanwhile stay pending. Pending sources are served lowest number first.
- R9: A request on a source whose enable bit is 0 is ignored.
- R10: For sources marked in FLAG_MASK, `flag_clr` pulses for one cycle with `flag_clr_src`, during the vector read.
- R11: A vector index of 24 or more ends the sequence after the vector read, with no write.
- R12: After reset, `busy`, `mem_req` and `irq` are 0 and `en_bits` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_req | input | NSRC | Activation request pulses, one per source |
| en_load | input | 1 | Loads en_load_val into the enable register |
| en_load_val | input | NSRC | New enable bits |
| en_bits | output | NSRC | Current activation-enable bits |
| nmi_flag | input | 1 | NMI flag; stops a chain at a link |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read |
| irq | output | 1 | One-cycle count-expiry interrupt |
| irq_src | output | log2(NSRC) | Source of the expiry |
| flag_clr | output | 1 | Clear pulse for the source's status flag |
| flag_clr_src | output | log2(NSRC) | Source whose flag is cleared |

## Verification
The following rules are checked on every cycle:
- `irq` lasts one cycle.
- A bus access only happens while `busy` is high.
- An idle sequencer issues no bus access and no `irq`.
- An `irq` leaves its enable bit clear.
- A flag clear comes with the vector read of that source.
- A data read is always followed by a write.
- A raised NMI flag at LINK returns the sequencer to IDLE.

Only the bench scenarios can show the rest:
- the values of the updated counts and addresses;
- the repeat-mode reload and rewind;
- the data actually copied;
- how far a chain runs;
- the service order of several pending sources;
- that disabled requests and invalid vectors leave memory untouched.

// File: rtl/cx_pkg.sv
package cx_pkg;

    typedef enum logic [3:0] {
        CX_IDLE,
        CX_VEC_REQ,
        CX_VEC_TAKE,
        CX_CD_W0,
        CX_CD_W1,
        CX_CD_W2,
        CX_CD_W3,
        CX_DATA_RD,
        CX_DATA_WR,
        CX_WB_CNT,
        CX_WB_SRC,
        CX_WB_DST,
        CX_LINK
    } cx_state_t;

    // control word bit positions (descriptor word 0)
    localparam int CTL_REPEAT = 0;
    localparam int CTL_CHAIN  = 1;
    localparam int CTL_RPTIRQ = 2;
    localparam int CTL_SRCINC = 3;
    localparam int CTL_DSTINC = 4;
    localparam int SIZE_LSB   = 16;

    localparam int CNT_W      = 16;

    // word offsets inside a descriptor
    localparam int OFS_CTL    = 0;
    localparam int OFS_CNT    = 1;
    localparam int OFS_SRC    = 2;
    localparam int OFS_DST    = 3;
    localparam int DESC_WORDS = 4;

endpackage

// File: rtl/cx_req_latch.sv
module cx_req_latch #(
    parameter int NSRC = 8,
    parameter int SW   = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] act_req,
    input  logic            en_load,
    input  logic [NSRC-1:0] en_load_val,
    input  logic            grant,
    input  logic [SW-1:0]   grant_src,
    input  logic            en_clr,
    input  logic [SW-1:0]   en_clr_src,
    output logic            pend_any,
    output logic [SW-1:0]   pick_src,
    output logic [NSRC-1:0] en_bits
);

    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] grant_mask;
    logic [NSRC-1:0] clr_mask;

    for (genvar g = 0; g < NSRC; g++) begin : g_mask
        assign grant_mask[g] = grant  && (grant_src  == SW'(g));
        assign clr_mask[g]   = en_clr && (en_clr_src == SW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= (pend_q & ~grant_mask) | (act_req & en_q);
            if (en_load) begin
                en_q <= en_load_val;
            end else begin
                en_q <= en_q & ~clr_mask;
            end
        end
    end

    // lowest-numbered pending source wins
    always_comb begin
        pick_src = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                pick_src = SW'(i);
            end
        end
    end

    assign pend_any = |pend_q;
    assign en_bits  = en_q;

endmodule

// File: rtl/cx_desc_step.sv
module cx_desc_step #(
    parameter int AW    = 8,
    parameter int CNT_W = 16
) (
    input  logic             rep,
    input  logic             rpt_irq,
    input  logic             src_inc,
    input  logic             dst_inc,
    input  logic [CNT_W-1:0] size,
    input  logic [CNT_W-1:0] cnt,
    input  logic [AW-1:0]    sa,
    input  logic [AW-1:0]    da,
    output logic [CNT_W-1:0] cnt_n,
    output logic [AW-1:0]    sa_n,
    output logic [AW-1:0]    da_n,
    output logic             expire
);

    logic last;
    logic wrap;
    logic [AW-1:0] sa_step;
    logic [AW-1:0] da_step;
    logic [AW-1:0] sa_rewind;
    logic [AW-1:0] da_rewind;

    assign last      = (cnt == CNT_W'(1));
    assign wrap      = rep && last;
    assign sa_step   = sa + AW'(1);
    assign da_step   = da + AW'(1);
    assign sa_rewind = sa + AW'(1) - AW'(size);
    assign da_rewind = da + AW'(1) - AW'(size);

    always_comb begin
        cnt_n  = wrap ? size : (cnt - CNT_W'(1));
        sa_n   = sa;
        da_n   = da;
        if (src_inc) begin
            sa_n = wrap ? sa_rewind : sa_step;
        end
        if (dst_inc) begin
            da_n = wrap ? da_rewind : da_step;
        end
        expire = last && (!rep || rpt_irq);
    end

endmodule

// File: rtl/cx_seq_fsm.sv
module cx_seq_fsm
    import cx_pkg::*;
#(
    parameter int              NSRC      = 8,
    parameter int              SW        = $clog2(NSRC),
    parameter int              AW        = 8,
    parameter int              DW        = 32,
    parameter int              NDESC     = 24,
    parameter int              IW        = $clog2(NDESC),
    parameter int              VEC_BASE  = 0,
    parameter int              DESC_BASE = 8,
    parameter logic [NSRC-1:0] FLAG_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend_any,
    input  logic [SW-1:0]    pick_src,
    input  logic             nmi_flag,
    input  logic [DW-1:0]    mem_rdata,
    input  logic [CNT_W-1:0] cnt_n,
    input  logic [AW-1:0]    sa_n,
    input  logic [AW-1:0]    da_n,
    input  logic             expire,
    output cx_state_t        state,
    output logic             grant,
    output logic [SW-1:0]    cur_src,
    output logic             rep,
    output logic             rpt_irq,
    output logic             src_inc,
    output logic             dst_inc,
    output logic [CNT_W-1:0] size,
    output logic [CNT_W-1:0] cnt,
    output logic [AW-1:0]    sa,
    output logic [AW-1:0]    da,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             busy,
    output logic             irq,
    output logic             flag_clr
);

    cx_state_t        state_q, state_d;
    logic [SW-1:0]    src_q;
    logic [IW-1:0]    idx_q;
    logic             rep_q, chain_q, rirq_q, sinc_q, dinc_q;
    logic [CNT_W-1:0] size_q, cnt_q;
    logic [AW-1:0]    sa_q, da_q;
    logic             exp_q;
    logic [AW-1:0]    desc_at;
    logic             vec_ok;
    logic             follow;

    assign desc_at = AW'(DESC_BASE) + AW'({idx_q, 2'b00});
    assign vec_ok  = mem_rdata[IW-1:0] < IW'(NDESC);
    assign follow  = chain_q && !nmi_flag && (idx_q != IW'(NDESC - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CX_IDLE:     if (pend_any) state_d = CX_VEC_REQ;
            CX_VEC_REQ:  state_d = CX_VEC_TAKE;
            CX_VEC_TAKE: state_d = vec_ok ? CX_CD_W0 : CX_IDLE;
            CX_CD_W0:    state_d = CX_CD_W1;
            CX_CD_W1:    state_d = CX_CD_W2;
            CX_CD_W2:    state_d = CX_CD_W3;
            CX_CD_W3:    state_d = CX_DATA_RD;
            CX_DATA_RD:  state_d = CX_DATA_WR;
            CX_DATA_WR:  state_d = CX_WB_CNT;
            CX_WB_CNT:   state_d = CX_WB_SRC;
            CX_WB_SRC:   state_d = CX_WB_DST;
            CX_WB_DST:   state_d = CX_LINK;
            CX_LINK:     state_d = follow ? CX_CD_W0 : CX_IDLE;
            default:     state_d = CX_IDLE;
        endcase
    end

    // state register and sequence data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CX_IDLE;
            src_q   <= '0;
            idx_q   <= '0;
            rep_q   <= 1'b0;
            chain_q <= 1'b0;
            rirq_q  <= 1'b0;
            sinc_q  <= 1'b0;
            dinc_q  <= 1'b0;
            size_q  <= '0;
            cnt_q   <= '0;
            sa_q    <= '0;
            da_q    <= '0;
            exp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                CX_IDLE: begin
                    if (pend_any) src_q <= pick_src;
                end
                CX_VEC_TAKE: idx_q <= mem_rdata[IW-1:0];
                CX_CD_W1: begin
                    rep_q   <= mem_rdata[CTL_REPEAT];
                    chain_q <= mem_rdata[CTL_CHAIN];
                    rirq_q  <= mem_rdata[CTL_RPTIRQ];
                    sinc_q  <= mem_rdata[CTL_SRCINC];
                    dinc_q  <= mem_rdata[CTL_DSTINC];
                    size_q  <= mem_rdata[SIZE_LSB +: CNT_W];
                end
                CX_CD_W2:   cnt_q <= mem_rdata[CNT_W-1:0];
                CX_CD_W3:   sa_q  <= mem_rdata[AW-1:0];
                CX_DATA_RD: da_q  <= mem_rdata[AW-1:0];
                CX_DATA_WR: begin
                    cnt_q <= cnt_n;
                    sa_q  <= sa_n;
                    da_q  <= da_n;
                    exp_q <= expire;
                end
                CX_LINK: begin
                    if (follow) idx_q <= idx_q + IW'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            CX_VEC_REQ: begin
                mem_req  = 1'b1;
                mem_addr = AW'(VEC_BASE) + AW'(src_q);
            end
            CX_CD_W0: begin
                mem_req  = 1'b1;
                mem_addr = desc_at + AW'(OFS_CTL);
            end
            CX_CD_W1: begin
                mem_req  = 1'b1;
                mem_addr = desc_at + AW'(OFS_CNT);
            end
            CX_CD_W2: begin
                mem_req  = 1'b1;
                mem_addr = desc_at + AW'(OFS_SRC);
            end
            CX_CD_W3: begin
                mem_req  = 1'b1;
                mem_addr = desc_at + AW'(OFS_DST);
            end
            CX_DATA_RD: begin
                mem_req  = 1'b1;
                mem_addr = sa_q;
            end
            CX_DATA_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = da_q;
                mem_wdata = mem_rdata;
            end
            CX_WB_CNT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_at + AW'(OFS_CNT);
                mem_wdata = DW'(cnt_q);
            end
            CX_WB_SRC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_at + AW'(OFS_SRC);
                mem_wdata = DW'(sa_q);
            end
            CX_WB_DST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_at + AW'(OFS_DST);
                mem_wdata = DW'(da_q);
            end
            default: ;
        endcase
    end

    assign state    = state_q;
    assign grant    = (state_q == CX_IDLE) && pend_any;
    assign cur_src  = src_q;
    assign busy     = (state_q != CX_IDLE);
    assign irq      = (state_q == CX_WB_CNT) && exp_q;
    assign flag_clr = (state_q == CX_VEC_REQ) && FLAG_MASK[src_q];
    assign rep      = rep_q;
    assign rpt_irq  = rirq_q;
    assign src_inc  = sinc_q;
    assign dst_inc  = dinc_q;
    assign size     = size_q;
    assign cnt      = cnt_q;
    assign sa       = sa_q;
    assign da       = da_q;

endmodule

// File: rtl/chain_xfer_ctrl.sv
module chain_xfer_ctrl
    import cx_pkg::*;
#(
    parameter int              NSRC      = 8,
    parameter int              AW        = 8,
    parameter int              DW        = 32,
    parameter int              NDESC     = 24,
    parameter int              VEC_BASE  = 0,
    parameter int              DESC_BASE = 8,
    parameter logic [NSRC-1:0] FLAG_MASK = 8'h30
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         act_req,
    input  logic                    en_load,
    input  logic [NSRC-1:0]         en_load_val,
    output logic [NSRC-1:0]         en_bits,
    input  logic                    nmi_flag,
    output logic                    busy,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [AW-1:0]           mem_addr,
    output logic [DW-1:0]           mem_wdata,
    input  logic [DW-1:0]           mem_rdata,
    output logic                    irq,
    output logic [$clog2(NSRC)-1:0] irq_src,
    output logic                    flag_clr,
    output logic [$clog2(NSRC)-1:0] flag_clr_src
);

    localparam int SW = $clog2(NSRC);
    localparam int IW = $clog2(NDESC);

    cx_state_t        seq_state;
    logic             pend_any, grant;
    logic [SW-1:0]    pick_src, cur_src;
    logic             rep, rpt_irq, src_inc, dst_inc, expire;
    logic [CNT_W-1:0] size, cnt, cnt_n;
    logic [AW-1:0]    sa, da, sa_n, da_n;

    cx_req_latch #(.NSRC(NSRC), .SW(SW)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_req     (act_req),
        .en_load     (en_load),
        .en_load_val (en_load_val),
        .grant       (grant),
        .grant_src   (pick_src),
        .en_clr      (irq),
        .en_clr_src  (cur_src),
        .pend_any    (pend_any),
        .pick_src    (pick_src),
        .en_bits     (en_bits)
    );

    cx_desc_step #(.AW(AW), .CNT_W(CNT_W)) u_step (
        .rep     (rep),
        .rpt_irq (rpt_irq),
        .src_inc (src_inc),
        .dst_inc (dst_inc),
        .size    (size),
        .cnt     (cnt),
        .sa      (sa),
        .da      (da),
        .cnt_n   (cnt_n),
        .sa_n    (sa_n),
        .da_n    (da_n),
        .expire  (expire)
    );

    cx_seq_fsm #(
        .NSRC(NSRC), .SW(SW), .AW(AW), .DW(DW), .NDESC(NDESC), .IW(IW),
        .VEC_BASE(VEC_BASE), .DESC_BASE(DESC_BASE), .FLAG_MASK(FLAG_MASK)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_any  (pend_any),
        .pick_src  (pick_src),
        .nmi_flag  (nmi_flag),
        .mem_rdata (mem_rdata),
        .cnt_n     (cnt_n),
        .sa_n      (sa_n),
        .da_n      (da_n),
        .expire    (expire),
        .state     (seq_state),
        .grant     (grant),
        .cur_src   (cur_src),
        .rep       (rep),
        .rpt_irq   (rpt_irq),
        .src_inc   (src_inc),
        .dst_inc   (dst_inc),
        .size      (size),
        .cnt       (cnt),
        .sa        (sa),
        .da        (da),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .irq       (irq),
        .flag_clr  (flag_clr)
    );

    assign irq_src      = cur_src;
    assign flag_clr_src = cur_src;

endmodule

// File: rtl/cx_checker.sv
module cx_checker
    import cx_pkg::*;
#(
    parameter int NSRC     = 8,
    parameter int AW       = 8,
    parameter int VEC_BASE = 0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    busy,
    input logic                    mem_req,
    input logic                    mem_we,
    input logic [AW-1:0]           mem_addr,
    input logic                    irq,
    input logic [$clog2(NSRC)-1:0] irq_src,
    input logic                    en_load,
    input logic [NSRC-1:0]         en_bits,
    input logic                    nmi_flag,
    input logic                    flag_clr,
    input logic [$clog2(NSRC)-1:0] flag_clr_src,
    input cx_state_t               seq_state
);

    localparam int SW = $clog2(NSRC);

    logic [SW-1:0] last_irq_src;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_irq_src <= '0;
        else        last_irq_src <= irq_src;
    end

    assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_en_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !en_load) |=> !en_bits[last_irq_src]);

    assert_bus_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !irq && !flag_clr));

    assert_flag_at_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |-> (mem_req && !mem_we && mem_addr == AW'(VEC_BASE) + AW'(flag_clr_src)));

    assert_read_then_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == CX_DATA_RD) |=> (mem_req && mem_we));

    assert_nmi_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == CX_LINK && nmi_flag) |=> (seq_state == CX_IDLE));

endmodule

bind chain_xfer_ctrl cx_checker #(.NSRC(NSRC), .AW(AW), .VEC_BASE(VEC_BASE)) u_cx_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .irq          (irq),
    .irq_src      (irq_src),
    .en_load      (en_load),
    .en_bits      (en_bits),
    .nmi_flag     (nmi_flag),
    .flag_clr     (flag_clr),
    .flag_clr_src (flag_clr_src),
    .seq_state    (seq_state)
);

// File: tb/test_chain_xfer_ctrl.sv
module test_chain_xfer_ctrl;

    localparam logic [7:0] FMASK = 8'h30;
    localparam int DBASE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  act_req = '0;
    logic        en_load = 1'b0;
    logic [7:0]  en_load_val = '0;
    logic [7:0]  en_bits;
    logic        nmi_flag = 1'b0;
    logic        busy, mem_req, mem_we, irq, flag_clr;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [2:0]  irq_src, flag_clr_src;

    logic [31:0] mem [256];

    int checks = 0;
    int errors = 0;
    int irq_cnt, flag_cnt, wr_cnt, busy_cyc, vlog_n;
    logic [2:0] last_irq_src;
    logic [7:0] vlog [8];

    always #5 clk = ~clk;

    chain_xfer_ctrl #(.FLAG_MASK(FMASK)) i_chain_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .act_req(act_req), .en_load(en_load),
        .en_load_val(en_load_val), .en_bits(en_bits), .nmi_flag(nmi_flag),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq), .irq_src(irq_src),
        .flag_clr(flag_clr), .flag_clr_src(flag_clr_src)
    );

    // memory model: read data one cycle later
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    // monitors
    always @(negedge clk) begin
        if (irq) begin
            irq_cnt++;
            last_irq_src = irq_src;
        end
        if (flag_clr) flag_cnt++;
        if (mem_req && mem_we) wr_cnt++;
        if (busy) busy_cyc++;
        if (mem_req && !mem_we && mem_addr < 8 && vlog_n < 8) begin
            vlog[vlog_n] = mem_addr;
            vlog_n++;
        end
    end

    function automatic logic [31:0] seed(input logic [7:0] a);
        return 32'hA5A5_0000 | 32'(a);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        irq_cnt = 0; flag_cnt = 0; wr_cnt = 0; busy_cyc = 0; vlog_n = 0;
    endtask

    task automatic load_en(input logic [7:0] v);
        @(negedge clk);
        en_load = 1'b1; en_load_val = v;
        @(negedge clk);
        en_load = 1'b0;
    endtask

    task automatic set_desc(input int idx, input logic [31:0] ctl, input logic [15:0] cnt,
                            input logic [7:0] sa, input logic [7:0] da);
        mem[DBASE + 4*idx]     = ctl;
        mem[DBASE + 4*idx + 1] = 32'(cnt);
        mem[DBASE + 4*idx + 2] = 32'(sa);
        mem[DBASE + 4*idx + 3] = 32'(da);
    endtask

    task automatic run_src(input int s);
        @(negedge clk);
        act_req[s] = 1'b1;
        @(negedge clk);
        act_req = '0;
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    typedef struct packed {
        logic [2:0]  src;
        logic [4:0]  idx;
        logic [31:0] ctl;
        logic [15:0] cnt;
        logic [7:0]  sa;
        logic [7:0]  da;
        logic [15:0] ecnt;
        logic [7:0]  esa;
        logic [7:0]  eda;
        logic        eirq;
    } vec_t;

    localparam vec_t TBL [7] = '{
        '{3'd1, 5'd3,  32'h0000_0018, 16'd5, 8'h80, 8'hC0, 16'd4,      8'h81, 8'hC1, 1'b0},
        '{3'd2, 5'd7,  32'h0000_0008, 16'd1, 8'h90, 8'hD0, 16'd0,      8'h91, 8'hD0, 1'b1},
        '{3'd3, 5'd10, 32'h0004_001D, 16'd1, 8'hA3, 8'hE3, 16'd4,      8'hA0, 8'hE0, 1'b1},
        '{3'd4, 5'd12, 32'h0003_0019, 16'd1, 8'hB2, 8'hF2, 16'd3,      8'hB0, 8'hF0, 1'b0},
        '{3'd5, 5'd23, 32'h0000_0000, 16'd0, 8'h85, 8'hC5, 16'hFFFF,   8'h85, 8'hC5, 1'b0},
        '{3'd0, 5'd0,  32'h0000_0010, 16'd2, 8'h88, 8'hC8, 16'd1,      8'h88, 8'hC9, 1'b0},
        '{3'd6, 5'd15, 32'h0002_0009, 16'd2, 8'h9A, 8'hDA, 16'd1,      8'h9B, 8'hDA, 1'b0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = seed(8'(a));
        clr_mon();
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 busy after reset", 32'(busy), 32'd0);
        check("R12 mem_req after reset", 32'(mem_req), 32'd0);
        check("R12 irq after reset", 32'(irq), 32'd0);
        check("R12 en_bits after reset", 32'(en_bits), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk: R1 R2 R5 R6 R7 R8 R10
        for (int e = 0; e < 7; e++) begin
            vec_t v;
            int d;
            v = TBL[e];
            d = DBASE + 4 * int'(v.idx);
            mem[v.src] = 32'(v.idx);
            set_desc(int'(v.idx), v.ctl, v.cnt, v.sa, v.da);
            load_en(8'hFF);
            clr_mon();
            run_src(int'(v.src));
            check("R1 data word copied", mem[v.da], seed(v.sa));
            check("R2 R5 R6 count written back", mem[d + 1], 32'(v.ecnt));
            check("R2 R6 source address", mem[d + 2], 32'(v.esa));
            check("R2 R6 destination address", mem[d + 3], 32'(v.eda));
            check("R5 R6 R7 irq pulses", 32'(irq_cnt), 32'(v.eirq));
            check("R5 R7 enable bit", 32'(en_bits[v.src]), 32'(!v.eirq));
            if (v.eirq) check("R5 irq_src", 32'(last_irq_src), 32'(v.src));
            check("R10 flag clear pulses", 32'(flag_cnt), 32'(FMASK[v.src]));
            check("R8 busy cycles single", 32'(busy_cyc), 32'd12);
            check("R1 writes per descriptor", 32'(wr_cnt), 32'd4);
        end

        // R3 chain of two descriptors
        mem[7] = 32'd20;
        set_desc(20, 32'h0000_000A, 16'd3, 8'h84, 8'hB8);
        set_desc(21, 32'h0000_0000, 16'd2, 8'h86, 8'hB9);
        load_en(8'hFF);
        clr_mon();
        run_src(7);
        check("R3 first link data", mem[8'hB8], seed(8'h84));
        check("R3 second link data", mem[8'hB9], seed(8'h86));
        check("R3 second link count", mem[DBASE + 4*21 + 1], 32'd1);
        check("R3 first link source inc", mem[DBASE + 4*20 + 2], 32'h85);
        check("R3 R8 busy cycles chained", 32'(busy_cyc), 32'd22);

        // R4 NMI stops the chain
        mem[7] = 32'd16;
        set_desc(16, 32'h0000_0002, 16'd5, 8'h8A, 8'hBA);
        set_desc(17, 32'h0000_0000, 16'd5, 8'h8B, 8'hBB);
        nmi_flag = 1'b1;
        clr_mon();
        run_src(7);
        nmi_flag = 1'b0;
        check("R4 first descriptor moved", mem[8'hBA], seed(8'h8A));
        check("R4 linked destination untouched", mem[8'hBB], seed(8'hBB));
        check("R4 linked count untouched", mem[DBASE + 4*17 + 1], 32'd5);
        check("R4 busy cycles", 32'(busy_cyc), 32'd12);

        // R9 disabled source ignored
        load_en(8'h7F);
        clr_mon();
        run_src(7);
        repeat (20) @(negedge clk);
        check("R9 no busy", 32'(busy_cyc), 32'd0);
        check("R9 no writes", 32'(wr_cnt), 32'd0);
        check("R9 destination unchanged", mem[8'hBB], seed(8'hBB));

        // R11 invalid vector index
        load_en(8'hFF);
        mem[7] = 32'd30;
        clr_mon();
        run_src(7);
        check("R11 no writes", 32'(wr_cnt), 32'd0);
        check("R11 busy cycles", 32'(busy_cyc), 32'd2);

        // R8 pending order: sources 1 and 2 together, 3 during busy
        load_en(8'hFF);
        clr_mon();
        @(negedge clk);
        act_req = 8'b0000_0110;
        @(negedge clk);
        act_req = '0;
        repeat (3) @(negedge clk);
        check("R8 busy while serving", 32'(busy), 32'd1);
        act_req = 8'b0000_1000;
        @(negedge clk);
        act_req = '0;
        repeat (120) @(negedge clk);
        check("R8 sequences served", 32'(vlog_n), 32'd3);
        check("R8 first served", 32'(vlog[0]), 32'd1);
        check("R8 second served", 32'(vlog[1]), 32'd2);
        check("R8 third served", 32'(vlog[2]), 32'd3);
        check("R8 idle at end", 32'(busy), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule